// File: doc/BRIEF.md
# Pad function selector

This block decides, pin by pin, which source drives each of up to 64 pads grouped into 32-pin banks. A pad can be a plain GPIO (function 0) or carry one of three alternate functions (1, 2, 3). Software programs the choice through three select registers per bank, named first, second and third. Setting a pin's bit in exactly one of them selects function 1, 2 or 3. Clearing the bit in all three returns the pin to GPIO. A fourth register per bank turns the pad's pull-up on or off.

The registers sit on a simple 32-bit word bus. A write takes effect whole, so software changes one pin with a read-modify-write. For every implemented pin the block drives a registered 2-bit function code and a registered pull-up enable toward the pad ring. Only pins 0 to 34 exist. Function 3 is missing on pins 10 to 19 and on pin 21. Bits that have no pin, or no third function, are not stored.

Top module: `pad_func_mux`

## Requirements
- R1: Reset (synchronous, active high) clears every select and pull-up register. After reset, every `func_code` field and every `pull_en` bit is 0, and every register reads back 0.
- R2: Register map by byte address on `addr`:
  - bank 0 (pins 0-31): first select 0x0C, second 0x14, third 0x8C
  - bank 1 (pins 32-63): first 0x10, second 0x18, third 0x90
  - pin n uses bank n/32, bit n%32
  - a written value reads back with unimplemented bits forced to 0
- R3: `func_code` holds 2 bits per pin, at bits [2n+1:2n] for pin n:
  - 1 when only the first select bit is set
  - 2 when only the second is set
  - 3 when only the third is set
  - 0 (GPIO) when none is set
- R4: When several select bits are set for one pin, third beats second, and second beats first.
- R5: Pull-up registers sit at 0xAC (bank 0) and 0xB0 (bank 1). One bit per pin, and 1 drives `pull_en[n]` high.
- R6: Bits for pins 35 and above (bank 1 bits 3-31) ignore writes and read 0 in all four bank-1 registers.
- R7: Third-select bits for pins 10-19 and 21 ignore writes and read 0. These pins never show function code 3.
- R8: Writes to any other address change nothing. Reads of any other address, including non-word-aligned ones, return 0.
- R9: Timing and idle read value:
  - a write sampled on a rising edge changes `func_code` and `pull_en` on the next rising edge
  - read data is valid after the rising edge that samples `rd_en`
  - `rd_data` is 0 in any cycle that follows no read

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for one cycle |
| rd_en | input | 1 | Read strobe for one cycle |
| addr | input | 8 | Byte address of the register |
| wdata | input | 32 | Write data |
| rd_data | output | 32 | Registered read data |
| func_code | output | 70 | 2-bit function code per pin, pin n at [2n+1:2n] |
| pull_en | output | 35 | Pull-up enable per pin |

## Verification
Read-back alone can hide faults, so the pad outputs are checked too. A stored bit that should have been masked shows up at once in the next read. For a third-select bit on a gap pin, it also shows as code 3 on that pin two edges after the write. A broken priority or bank mapping shows as a wrong 2-bit field or pull-up on a named pin, one edge after the register changes. An extra or missing pipeline stage moves the output change by one cycle, and the latency check samples on both sides of that edge.

// File: rtl/pmx_pkg.sv
package pmx_pkg;

  typedef enum logic [1:0] {
    K_PRI  = 2'd0,
    K_SEC  = 2'd1,
    K_TER  = 2'd2,
    K_PULL = 2'd3
  } reg_kind_e;

  localparam int NUM_KINDS = 4;

  localparam logic [1:0] FN_GPIO = 2'd0;
  localparam logic [1:0] FN_ALT1 = 2'd1;
  localparam logic [1:0] FN_ALT2 = 2'd2;
  localparam logic [1:0] FN_ALT3 = 2'd3;

  // pins with no third function
  localparam int ALT3_GAP_LO  = 10;
  localparam int ALT3_GAP_HI  = 19;
  localparam int ALT3_GAP_ONE = 21;

  function automatic logic alt3_ok(input int pin);
    return !((pin >= ALT3_GAP_LO && pin <= ALT3_GAP_HI) || pin == ALT3_GAP_ONE);
  endfunction

  // returns {valid, byte offset}
  function automatic logic [8:0] reg_offset(input reg_kind_e k, input int bank);
    logic [8:0] r;
    r = 9'h000;
    if (bank == 0) begin
      case (k)
        K_PRI:   r = {1'b1, 8'h0C};
        K_SEC:   r = {1'b1, 8'h14};
        K_TER:   r = {1'b1, 8'h8C};
        default: r = {1'b1, 8'hAC};
      endcase
    end else if (bank == 1) begin
      case (k)
        K_PRI:   r = {1'b1, 8'h10};
        K_SEC:   r = {1'b1, 8'h18};
        K_TER:   r = {1'b1, 8'h90};
        default: r = {1'b1, 8'hB0};
      endcase
    end
    return r;
  endfunction

endpackage

// File: rtl/pmx_addr_dec.sv
module pmx_addr_dec
  import pmx_pkg::*;
#(
  parameter int ADDR_W     = 8,
  parameter int NUM_BANKS  = 2,
  parameter int BANK_IDX_W = 1
) (
  input  logic [ADDR_W-1:0]     addr,
  output logic                  hit,
  output reg_kind_e             kind,
  output logic [BANK_IDX_W-1:0] bank
);

  always_comb begin
    hit  = 1'b0;
    kind = K_PRI;
    bank = '0;
    for (int b = 0; b < NUM_BANKS; b++) begin
      for (int k = 0; k < NUM_KINDS; k++) begin
        logic [8:0] off;
        off = reg_offset(reg_kind_e'(2'(k)), b);
        if (off[8] && addr == ADDR_W'(off[7:0])) begin
          hit  = 1'b1;
          kind = reg_kind_e'(2'(k));
          bank = BANK_IDX_W'(b);
        end
      end
    end
  end

endmodule

// File: rtl/pmx_regfile.sv
module pmx_regfile
  import pmx_pkg::*;
#(
  parameter int NUM_PINS   = 35,
  parameter int NUM_BANKS  = 2,
  parameter int BANK_W     = 32,
  parameter int BANK_IDX_W = 1
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic                              wr_en,
  input  logic                              rd_en,
  input  logic                              hit,
  input  reg_kind_e                         kind,
  input  logic [BANK_IDX_W-1:0]             bank,
  input  logic [BANK_W-1:0]                 wdata,
  output logic [BANK_W-1:0]                 rd_data,
  output logic [NUM_BANKS-1:0][BANK_W-1:0]  pri_q,
  output logic [NUM_BANKS-1:0][BANK_W-1:0]  sec_q,
  output logic [NUM_BANKS-1:0][BANK_W-1:0]  ter_q,
  output logic [NUM_BANKS-1:0][BANK_W-1:0]  pu_q
);

  function automatic logic [NUM_BANKS-1:0][BANK_W-1:0] build_mask(input logic third);
    logic [NUM_BANKS-1:0][BANK_W-1:0] m;
    m = '0;
    for (int b = 0; b < NUM_BANKS; b++) begin
      for (int i = 0; i < BANK_W; i++) begin
        int pin;
        pin = b * BANK_W + i;
        m[b][i] = (pin < NUM_PINS) && (!third || alt3_ok(pin));
      end
    end
    return m;
  endfunction

  localparam logic [NUM_BANKS-1:0][BANK_W-1:0] MASK_ANY = build_mask(1'b0);
  localparam logic [NUM_BANKS-1:0][BANK_W-1:0] MASK_TER = build_mask(1'b1);

  logic [BANK_W-1:0] rd_sel;

  always_ff @(posedge clk) begin
    if (rst) begin
      pri_q <= '0;
      sec_q <= '0;
      ter_q <= '0;
      pu_q  <= '0;
    end else if (wr_en && hit) begin
      case (kind)
        K_PRI:   pri_q[bank] <= wdata & MASK_ANY[bank];
        K_SEC:   sec_q[bank] <= wdata & MASK_ANY[bank];
        K_TER:   ter_q[bank] <= wdata & MASK_TER[bank];
        default: pu_q[bank]  <= wdata & MASK_ANY[bank];
      endcase
    end
  end

  always_comb begin
    case (kind)
      K_PRI:   rd_sel = pri_q[bank];
      K_SEC:   rd_sel = sec_q[bank];
      K_TER:   rd_sel = ter_q[bank];
      default: rd_sel = pu_q[bank];
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data <= '0;
    end else begin
      rd_data <= (rd_en && hit) ? rd_sel : '0;
    end
  end

endmodule

// File: rtl/pmx_decode.sv
module pmx_decode
  import pmx_pkg::*;
#(
  parameter int NUM_PINS  = 35,
  parameter int NUM_BANKS = 2,
  parameter int BANK_W    = 32
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic [NUM_BANKS-1:0][BANK_W-1:0]  pri_q,
  input  logic [NUM_BANKS-1:0][BANK_W-1:0]  sec_q,
  input  logic [NUM_BANKS-1:0][BANK_W-1:0]  ter_q,
  input  logic [NUM_BANKS-1:0][BANK_W-1:0]  pu_q,
  output logic [2*NUM_PINS-1:0]             func_code,
  output logic [NUM_PINS-1:0]               pull_en
);

  logic [NUM_PINS-1:0][1:0] fn_d;
  logic [NUM_PINS-1:0]      pu_d;

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    localparam int B = p / BANK_W;
    localparam int I = p % BANK_W;
    assign fn_d[p] = ter_q[B][I] ? FN_ALT3 :
                     sec_q[B][I] ? FN_ALT2 :
                     pri_q[B][I] ? FN_ALT1 : FN_GPIO;
    assign pu_d[p] = pu_q[B][I];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      func_code <= '0;
      pull_en   <= '0;
    end else begin
      func_code <= fn_d;
      pull_en   <= pu_d;
    end
  end

endmodule

// File: rtl/pad_func_mux.sv
module pad_func_mux
  import pmx_pkg::*;
#(
  parameter int NUM_PINS  = 35,
  parameter int BANK_W    = 32,
  parameter int ADDR_W    = 8,
  parameter int NUM_BANKS = (NUM_PINS + BANK_W - 1) / BANK_W
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   wr_en,
  input  logic                   rd_en,
  input  logic [ADDR_W-1:0]      addr,
  input  logic [BANK_W-1:0]      wdata,
  output logic [BANK_W-1:0]      rd_data,
  output logic [2*NUM_PINS-1:0]  func_code,
  output logic [NUM_PINS-1:0]    pull_en
);

  localparam int BANK_IDX_W = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1;

  logic                             hit;
  reg_kind_e                        kind;
  logic [BANK_IDX_W-1:0]            bank;
  logic [NUM_BANKS-1:0][BANK_W-1:0] pri_q, sec_q, ter_q, pu_q;

  pmx_addr_dec #(
    .ADDR_W(ADDR_W), .NUM_BANKS(NUM_BANKS), .BANK_IDX_W(BANK_IDX_W)
  ) addr_dec_i (
    .addr(addr), .hit(hit), .kind(kind), .bank(bank)
  );

  pmx_regfile #(
    .NUM_PINS(NUM_PINS), .NUM_BANKS(NUM_BANKS), .BANK_W(BANK_W), .BANK_IDX_W(BANK_IDX_W)
  ) regfile_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .hit(hit), .kind(kind),
    .bank(bank), .wdata(wdata), .rd_data(rd_data),
    .pri_q(pri_q), .sec_q(sec_q), .ter_q(ter_q), .pu_q(pu_q)
  );

  pmx_decode #(
    .NUM_PINS(NUM_PINS), .NUM_BANKS(NUM_BANKS), .BANK_W(BANK_W)
  ) decode_i (
    .clk(clk), .rst(rst), .pri_q(pri_q), .sec_q(sec_q), .ter_q(ter_q), .pu_q(pu_q),
    .func_code(func_code), .pull_en(pull_en)
  );

endmodule

// File: rtl/pad_func_mux_chk.sv
module pad_func_mux_chk #(
  parameter int NUM_PINS = 35,
  parameter int BANK_W   = 32,
  parameter int ADDR_W   = 8
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  wr_en,
  input logic                  rd_en,
  input logic [ADDR_W-1:0]     addr,
  input logic [BANK_W-1:0]     rd_data,
  input logic [2*NUM_PINS-1:0] func_code,
  input logic [NUM_PINS-1:0]   pull_en
);

  localparam int LAST_BITS = NUM_PINS - BANK_W * ((NUM_PINS - 1) / BANK_W);

  logic rst_q;
  logic bank1_reg;
  logic mapped;

  assign bank1_reg = (addr == ADDR_W'(8'h10)) || (addr == ADDR_W'(8'h18)) ||
                     (addr == ADDR_W'(8'h90)) || (addr == ADDR_W'(8'hB0));
  assign mapped = bank1_reg ||
                  (addr == ADDR_W'(8'h0C)) || (addr == ADDR_W'(8'h14)) ||
                  (addr == ADDR_W'(8'h8C)) || (addr == ADDR_W'(8'hAC));

  always_ff @(posedge clk) begin
    rst_q <= rst;
    if (rst_q === 1'b1 && rst === 1'b0) begin
      // R1
      reset_out_chk: assert (func_code == '0 && pull_en == '0);
    end
  end

  // R6
  upper_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_en && bank1_reg) |=> ((rd_data >> LAST_BITS) == '0));

  // R8
  unmapped_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_en && !mapped) |=> (rd_data == '0));

  // R9
  func_latency_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(func_code) |-> $past(wr_en, 2));

  // R9
  pull_latency_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(pull_en) |-> $past(wr_en, 2));

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_gap
    if ((p >= 10 && p <= 19) || p == 21) begin : g_on
      // R7
      gap_no_alt3_chk: assert property (@(posedge clk) disable iff (rst)
        func_code[2*p +: 2] != 2'd3);
    end
  end

endmodule

bind pad_func_mux pad_func_mux_chk #(
  .NUM_PINS(NUM_PINS), .BANK_W(BANK_W), .ADDR_W(ADDR_W)
) chk_i (.*);

// File: tb/pad_func_mux_tb_top.sv
`timescale 1ns/1ps
module pad_func_mux_tb_top;

  localparam int NP = 35;
  localparam int NV = 34;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          wr_en = 1'b0;
  logic          rd_en = 1'b0;
  logic [7:0]    addr = '0;
  logic [31:0]   wdata = '0;
  logic [31:0]   rd_data;
  logic [2*NP-1:0] func_code;
  logic [NP-1:0] pull_en;

  int vectors = 0;
  int miscompares = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  pad_func_mux dut_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rd_data(rd_data), .func_code(func_code), .pull_en(pull_en)
  );

  // {req[3:0], is_read, addr[7:0], data[31:0], expected[31:0]}
  localparam logic [76:0] VEC [NV] = '{
    {4'd1, 1'b1, 8'h0C, 32'h0,        32'h0},         // R1
    {4'd2, 1'b0, 8'h0C, 32'hFFFFFFFF, 32'h0},         // R2
    {4'd2, 1'b1, 8'h0C, 32'h0,        32'hFFFFFFFF},  // R2
    {4'd6, 1'b0, 8'h10, 32'hFFFFFFFF, 32'h0},         // R6
    {4'd6, 1'b1, 8'h10, 32'h0,        32'h00000007},  // R6
    {4'd7, 1'b0, 8'h8C, 32'hFFFFFFFF, 32'h0},         // R7
    {4'd7, 1'b1, 8'h8C, 32'h0,        32'hFFD003FF},  // R7
    {4'd6, 1'b0, 8'h90, 32'hFFFFFFFF, 32'h0},         // R6
    {4'd6, 1'b1, 8'h90, 32'h0,        32'h00000007},  // R6
    {4'd2, 1'b0, 8'h14, 32'hA5A5A5A5, 32'h0},         // R2
    {4'd2, 1'b1, 8'h14, 32'h0,        32'hA5A5A5A5},  // R2
    {4'd6, 1'b0, 8'h18, 32'hFFFFFFFE, 32'h0},         // R6
    {4'd6, 1'b1, 8'h18, 32'h0,        32'h00000006},  // R6
    {4'd5, 1'b0, 8'hAC, 32'h12345678, 32'h0},         // R5
    {4'd5, 1'b1, 8'hAC, 32'h0,        32'h12345678},  // R5
    {4'd6, 1'b0, 8'hB0, 32'hFFFFFFF8, 32'h0},         // R6
    {4'd6, 1'b1, 8'hB0, 32'h0,        32'h0},         // R6
    {4'd8, 1'b0, 8'h00, 32'hFFFFFFFF, 32'h0},         // R8
    {4'd8, 1'b1, 8'h00, 32'h0,        32'h0},         // R8
    {4'd8, 1'b1, 8'h04, 32'h0,        32'h0},         // R8
    {4'd8, 1'b1, 8'h0D, 32'h0,        32'h0},         // R8
    {4'd8, 1'b1, 8'h88, 32'h0,        32'h0},         // R8
    {4'd8, 1'b1, 8'h0C, 32'h0,        32'hFFFFFFFF},  // R8
    {4'd2, 1'b0, 8'h0C, 32'h0,        32'h0},
    {4'd2, 1'b0, 8'h10, 32'h0,        32'h0},
    {4'd2, 1'b0, 8'h14, 32'h0,        32'h0},
    {4'd2, 1'b0, 8'h18, 32'h0,        32'h0},
    {4'd2, 1'b0, 8'h8C, 32'h0,        32'h0},
    {4'd2, 1'b0, 8'h90, 32'h0,        32'h0},
    {4'd2, 1'b0, 8'hAC, 32'h0,        32'h0},
    {4'd2, 1'b0, 8'hB0, 32'h0,        32'h0},
    {4'd2, 1'b1, 8'h0C, 32'h0,        32'h0},         // R2
    {4'd7, 1'b1, 8'h8C, 32'h0,        32'h0},         // R7
    {4'd5, 1'b1, 8'hAC, 32'h0,        32'h0}          // R5
  };

  task automatic check(input bit ok, input string req, input logic [69:0] act,
                       input logic [69:0] exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_write(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic do_read(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    d = rd_data;
  endtask

  task automatic settle();
    @(negedge clk);
    @(negedge clk);
  endtask

  function automatic logic [1:0] pin_fn(input int p);
    return func_code[2*p +: 2];
  endfunction

  task automatic check_pin(input int p, input logic [1:0] exp, input string req);
    check(pin_fn(p) == exp, $sformatf("%s pin%0d", req, p), 70'(pin_fn(p)), 70'(exp));
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    vectors++;
    miscompares++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    logic [31:0]     rv;
    logic [2*NP-1:0] fc_snap;
    logic [NP-1:0]   pu_snap;

    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 outputs after reset
    check(func_code == '0, "R1 func_code", 70'(func_code), 70'(0));
    check(pull_en == '0, "R1 pull_en", 70'(pull_en), 70'(0));

    for (int i = 0; i < NV; i++) begin
      logic [76:0] v;
      v = VEC[i];
      if (v[72]) begin
        do_read(v[71:64], rv);
        check(rv == v[31:0], $sformatf("R%0d read 0x%02h", v[76:73], v[71:64]),
              70'(rv), 70'(v[31:0]));
      end else begin
        do_write(v[71:64], v[63:32]);
      end
    end

    // R3 single select per pin
    do_write(8'h0C, 32'h1 << 5);
    do_write(8'h18, 32'h1 << 1);
    do_write(8'h90, 32'h1 << 2);
    settle();
    check_pin(5, 2'd1, "R3");
    check_pin(33, 2'd2, "R3");
    check_pin(34, 2'd3, "R3");
    check_pin(0, 2'd0, "R3");

    // R4 priority among overlapping selects
    do_write(8'h0C, (32'h1 << 5) | (32'h1 << 4) | (32'h1 << 7));
    do_write(8'h14, 32'h1 << 4);
    do_write(8'h8C, 32'h1 << 7);
    settle();
    check_pin(4, 2'd2, "R4");
    check_pin(7, 2'd3, "R4");
    do_write(8'h8C, (32'h1 << 7) | (32'h1 << 4));
    settle();
    check_pin(4, 2'd3, "R4");

    // R7 third function missing on gap pins
    do_write(8'h0C, (32'h1 << 5) | (32'h1 << 4) | (32'h1 << 7) | (32'h1 << 12));
    do_write(8'h8C, (32'h1 << 12) | (32'h1 << 21) | (32'h1 << 20));
    settle();
    check_pin(12, 2'd1, "R7");
    check_pin(21, 2'd0, "R7");
    check_pin(20, 2'd3, "R7");

    // R5 pull-up bits per bank
    do_write(8'hAC, 32'h1 << 3);
    do_write(8'hB0, 32'h1 << 2);
    settle();
    check(pull_en == ((NP'(1) << 3) | (NP'(1) << 34)), "R5 pull_en",
          70'(pull_en), 70'((NP'(1) << 3) | (NP'(1) << 34)));

    // R2 bank 1 bit 0 is pin 32
    do_write(8'h10, 32'h1);
    settle();
    check_pin(32, 2'd1, "R2");

    // R9 output latency: one edge after write still old, next edge new
    @(negedge clk);
    wr_en = 1'b1; addr = 8'h0C;
    wdata = (32'h1 << 5) | (32'h1 << 4) | (32'h1 << 7) | (32'h1 << 12) | (32'h1 << 9);
    @(negedge clk);
    wr_en = 1'b0;
    check_pin(9, 2'd0, "R9 early");
    @(negedge clk);
    check_pin(9, 2'd1, "R9 due");
    check(rd_data == '0, "R9 idle rd_data", 70'(rd_data), 70'(0));

    // R8 unmapped writes leave outputs alone
    fc_snap = func_code;
    pu_snap = pull_en;
    do_write(8'h00, 32'hFFFFFFFF);
    do_write(8'h98, 32'hFFFFFFFF);
    do_write(8'hAD, 32'hFFFFFFFF);
    settle();
    check(func_code == fc_snap, "R8 func_code", 70'(func_code), 70'(fc_snap));
    check(pull_en == pu_snap, "R8 pull_en", 70'(pull_en), 70'(pu_snap));

    // R1 reset in mid-run
    @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(func_code == '0, "R1 func_code mid-run", 70'(func_code), 70'(0));
    check(pull_en == '0, "R1 pull_en mid-run", 70'(pull_en), 70'(0));
    do_read(8'h0C, rv);
    check(rv == '0, "R1 read 0x0C", 70'(rv), 70'(0));
    do_read(8'hB0, rv);
    check(rv == '0, "R1 read 0xB0", 70'(rv), 70'(0));

    finish_run();
  end

endmodule